// File: doc/BRIEF.md
# Multirate Phased Clock-Enable Controller

This block produces the clock-enable strobes for a design in which several sample rates share one clock. It runs on a single primary clock at the base rate, which is the fastest rate in the design. A single base enable input, `ce_in`, gates everything. The block passes `ce_in` through as the base-rate enable. For every slower rate it derives one strobe per phase of that rate's period. Each slower rate is an integer fraction of the base rate, and its factor is fixed at elaboration.

Rates that have the same factor share one divider counter. The number of counters is therefore the number of distinct factors. Each rate decodes a one-cycle enable for every phase from its shared counter. Two output-valid strobes tell downstream logic when results are updated:

- `vld_base` marks the base-rate updates.
- `vld_slow` is tied to phase 1 of a chosen slow rate. By default this is rate 0, which divides by 2.

The block moves no data, so it has no valid/ready interface. All of its pins are plain control strobes with no back-pressure.

Top module: `mrate_enable_gen`

## Requirements
- R1: `ce_base` equals `ce_in` in the same cycle, including during reset.
- R2: The factor of rate i is the field `RATE_FACTORS[i*FACT_W +: FACT_W]`. The phase-k enable of rate i is bit `B_i + k` of `en_phase`, where `B_i` is the sum of the factors of rates 0 to i-1.
- R3: Let n be the number of base cycles since the last reset that had `ce_in` high and reset low. The phase-k enable of rate i is high exactly when `ce_in` is high and n mod F_i equals k. Each phase therefore fires once every F_i enabled base cycles.
- R4: While `ce_in` is low, every bit of `en_phase` and `vld_slow` is low. The counters hold their values, so the next enabled cycle continues the sequence where it stopped.
- R5: The first enabled cycle after reset raises the phase-0 enable of every rate in that same cycle.
- R6: Rates with equal factors produce identical enable patterns, because they are driven by one shared counter.
- R7: In every cycle with `ce_in` high, exactly one phase enable of each rate is high.
- R8: `vld_base` equals `ce_in`. `vld_slow` equals the phase-1 enable of rate `VALID_RATE`.
- R9: Reset is synchronous and active high. A clock edge with `rst` high returns every counter to phase 0, and `ce_in` does not advance the counters on that edge.
- R10: A rate with factor 1 has a single enable, and that enable equals `ce_base`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Primary clock at the base rate |
| rst | input | 1 | Synchronous active-high reset of all divider counters |
| ce_in | input | 1 | Base-rate enable that gates all counting |
| ce_base | output | 1 | Base-rate enable, equal to `ce_in` |
| en_phase | output | TOTAL_PH | Per-rate, per-phase enables, packed as in R2 |
| vld_base | output | 1 | Output-valid strobe for base-rate results |
| vld_slow | output | 1 | Output-valid strobe for the selected slow rate (its phase 1) |

## Verification
Every output is a combinational function of `ce_in` and the registered counters. A change on `ce_in` is therefore due in the same cycle, and the effect of an enabled or reset edge on the phase pattern is due in the cycle after that edge. The bench drives `ce_in` and `rst` at the falling edge and samples all outputs 2 ns later. Only after sampling does it advance its arithmetic model (the enabled-cycle count n, reduced modulo each factor) for the coming rising edge, so each check compares against the state the design holds in that cycle. The stimulus sweeps all 256 eight-cycle enable patterns, long enabled runs, idle stretches and resets placed both mid-period and while `ce_in` is high.

// File: rtl/mrate_pkg.sv
package mrate_pkg;

  // Field width of one rate factor. A counter value also fits in this width.
  localparam int unsigned FACT_W = 4;

  typedef logic [FACT_W-1:0] fact_t;

  // Next counter value for a divide-by-factor counter that wraps at factor-1.
  function automatic fact_t next_count(input fact_t cur, input int unsigned factor);
    if (factor <= 1) return '0;
    if (int'(cur) >= int'(factor) - 1) return '0;
    return cur + fact_t'(1);
  endfunction

endpackage

// File: rtl/mrate_div_counter.sv
module mrate_div_counter
  import mrate_pkg::*;
#(
  parameter int unsigned FACTOR = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  output fact_t phase
);

  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= next_count(phase, FACTOR);
  end

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(phase) < int'(FACTOR));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(phase));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && phase == fact_t'(FACTOR - 1)) |=> (phase == '0));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && int'(phase) < int'(FACTOR) - 1) |=> (phase == fact_t'($past(phase) + fact_t'(1))));

endmodule

// File: rtl/mrate_phase_decode.sv
module mrate_phase_decode
  import mrate_pkg::*;
#(
  parameter int unsigned FACTOR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  fact_t             phase,
  output logic [FACTOR-1:0] en
);

  for (genvar k = 0; k < FACTOR; k++) begin : g_ph
    assign en[k] = ce && (phase == fact_t'(k));
  end

  // R7
  one_phase_chk: assert property (@(posedge clk) disable iff (rst)
    ce |-> ($countones(en) == 1));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |-> (en == '0));

  // R7
  at_most_one_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en));

endmodule

// File: rtl/mrate_enable_gen.sv
module mrate_enable_gen
  import mrate_pkg::*;
#(
  parameter int unsigned NUM_RATES = 5,
  parameter logic [NUM_RATES*FACT_W-1:0] RATE_FACTORS = {4'd1, 4'd4, 4'd2, 4'd3, 4'd2},
  parameter int unsigned VALID_RATE = 0,
  localparam int unsigned TOTAL_PH = total_phases()
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce_in,
  output logic                ce_base,
  output logic [TOTAL_PH-1:0] en_phase,
  output logic                vld_base,
  output logic                vld_slow
);

  function automatic int unsigned factor_of(input int unsigned i);
    return int'(RATE_FACTORS[i*FACT_W +: FACT_W]);
  endfunction

  function automatic int unsigned total_phases();
    int unsigned s = 0;
    for (int j = 0; j < NUM_RATES; j++) s += factor_of(j);
    return s;
  endfunction

  function automatic int unsigned first_of(input int unsigned i);
    for (int j = 0; j < NUM_RATES; j++)
      if (factor_of(j) == factor_of(i)) return j;
    return i;
  endfunction

  function automatic int unsigned num_uniq();
    int unsigned c = 0;
    for (int j = 0; j < NUM_RATES; j++) if (first_of(j) == j) c++;
    return c;
  endfunction

  function automatic int unsigned uniq_rate(input int unsigned u);
    int unsigned c = 0;
    for (int j = 0; j < NUM_RATES; j++) begin
      if (first_of(j) == j) begin
        if (c == u) return j;
        c++;
      end
    end
    return 0;
  endfunction

  function automatic int unsigned slot_of(input int unsigned i);
    int unsigned c = 0;
    for (int j = 0; j < NUM_RATES; j++)
      if (j < first_of(i) && first_of(j) == j) c++;
    return c;
  endfunction

  function automatic int unsigned phase_base(input int unsigned i);
    int unsigned s = 0;
    for (int j = 0; j < NUM_RATES; j++) if (j < i) s += factor_of(j);
    return s;
  endfunction

  function automatic logic [TOTAL_PH-1:0] ph0_mask();
    logic [TOTAL_PH-1:0] m = '0;
    for (int j = 0; j < NUM_RATES; j++) m[phase_base(j)] = 1'b1;
    return m;
  endfunction

  localparam int unsigned NUM_UNIQ = num_uniq();
  localparam int unsigned VIDX = phase_base(VALID_RATE) + ((factor_of(VALID_RATE) > 1) ? 1 : 0);
  localparam logic [TOTAL_PH-1:0] PH0_MASK = ph0_mask();

  // One divider per distinct factor.
  fact_t cnt_u [NUM_UNIQ];

  for (genvar u = 0; u < NUM_UNIQ; u++) begin : g_div
    mrate_div_counter #(.FACTOR(factor_of(uniq_rate(u)))) u_div (
      .clk   (clk),
      .rst   (rst),
      .adv   (ce_in),
      .phase (cnt_u[u])
    );
  end

  // One phase decoder per rate, each reading its shared counter.
  for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
    localparam int unsigned SLOT = slot_of(i);
    localparam int unsigned FI   = factor_of(i);
    localparam int unsigned BI   = phase_base(i);

    mrate_phase_decode #(.FACTOR(FI)) u_dec (
      .clk   (clk),
      .rst   (rst),
      .ce    (ce_in),
      .phase (cnt_u[SLOT]),
      .en    (en_phase[BI +: FI])
    );

    if (first_of(i) != i) begin : g_shared
      localparam int unsigned BF = phase_base(first_of(i));
      // R6
      shared_rate_chk: assert property (@(posedge clk) disable iff (rst)
        en_phase[BI +: FI] == en_phase[BF +: FI]);
    end

    if (FI == 1) begin : g_unit
      // R10
      unit_rate_chk: assert property (@(posedge clk) disable iff (rst)
        en_phase[BI] == ce_base);
    end
  end

  assign ce_base  = ce_in;
  assign vld_base = ce_in;
  assign vld_slow = en_phase[VIDX];

  // Tracks whether an enabled cycle has occurred since reset (checker state only).
  logic fresh;
  always_ff @(posedge clk) begin
    if (rst)        fresh <= 1'b1;
    else if (ce_in) fresh <= 1'b0;
  end

  // R5
  first_phase0_chk: assert property (@(posedge clk) disable iff (rst)
    (fresh && ce_in) |-> ((en_phase & PH0_MASK) == PH0_MASK));

  // R8
  slow_valid_chk: assert property (@(posedge clk) disable iff (rst)
    vld_slow |-> vld_base);

  // R9
  reset_phase0_chk: assert property (@(posedge clk)
    rst |=> (ce_in |-> ((en_phase & PH0_MASK) == PH0_MASK)));

endmodule

// File: tb/mrate_enable_gen_tb.sv
`timescale 1ns/1ps
module mrate_enable_gen_tb_top;
  localparam int NR = 5;
  localparam int FW = mrate_pkg::FACT_W;
  localparam int FAC [NR] = '{2, 3, 2, 4, 1};
  localparam int TP = 12;
  localparam logic [NR*FW-1:0] RF = {4'd1, 4'd4, 4'd2, 4'd3, 4'd2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_in = 1'b0;
  logic ce_base, vld_base, vld_slow;
  logic [TP-1:0] en_phase;

  int n_cmp = 0;
  int n_bad = 0;
  int n_en = 0;
  bit fresh = 1'b1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mrate_enable_gen #(.NUM_RATES(NR), .RATE_FACTORS(RF), .VALID_RATE(0)) dut_i (
    .clk(clk), .rst(rst), .ce_in(ce_in), .ce_base(ce_base),
    .en_phase(en_phase), .vld_base(vld_base), .vld_slow(vld_slow)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int base_of(input int i);
    int s = 0;
    for (int j = 0; j < i; j++) s += FAC[j];
    return s;
  endfunction

  task automatic step(input bit ce, input bit r);
    logic [TP-1:0] exp;
    string tg;
    @(negedge clk);
    ce_in = ce;
    rst = r;
    #2;
    exp = '0;
    for (int i = 0; i < NR; i++)
      for (int k = 0; k < FAC[i]; k++)
        exp[base_of(i) + k] = ce && ((n_en % FAC[i]) == k);
    if (r)          tg = "R9 en_phase in reset cycle";
    else if (!ce)   tg = "R4 en_phase idle";
    else if (fresh) tg = "R5 en_phase first enable";
    else            tg = "R2 R3 en_phase";
    chk("R1 ce_base", 32'(ce_base), 32'(ce));
    chk(tg, 32'(en_phase), 32'(exp));
    chk("R8 vld_base", 32'(vld_base), 32'(ce));
    chk("R8 vld_slow", 32'(vld_slow), 32'(ce && (n_en % 2) == 1));
    for (int i = 0; i < NR; i++)
      chk("R7 phases per rate", 32'($countones(en_phase[base_of(i) +: 4] & 4'((1 << FAC[i]) - 1))),
          32'(ce ? 1 : 0));
    chk("R6 shared rates 0 and 2", 32'(en_phase[1:0]), 32'(en_phase[6:5]));
    chk("R10 unit rate", 32'(en_phase[TP-1]), 32'(ce_base));
    if (r) begin
      n_en = 0;
      fresh = 1'b1;
    end else if (ce) begin
      n_en++;
      fresh = 1'b0;
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    n_en = 0;
    fresh = 1'b1;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    for (int c = 0; c < 40; c++) step(1'b1, 1'b0);
    for (int p = 0; p < 256; p++) begin
      if (p % 37 == 0) step(p[0], 1'b1);
      for (int b = 0; b < 8; b++) step(p[b], 1'b0);
    end
    lfsr = 16'hACE1;
    for (int c = 0; c < 800; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], (lfsr[11:4] == 8'h5A));
    end
    for (int c = 0; c < 20; c++) step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    for (int c = 0; c < 30; c++) step(1'b1, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule